// File: doc/BRIEF.md
# Control-Flow Next-PC Unit

This block resolves where execution goes next for the control-flow instructions of a small 8-bit processor core, and how many cycles the instruction costs. The decode stage presents an operation code together with the current program counter, a signed relative displacement, the status byte, a condition selector with its polarity, the precomputed skip condition, a flag telling whether the following instruction occupies two words, and the return address from the top of the hardware stack. One clock later the unit reports the next program counter, whether control flow left the sequential path, the cycle cost, and a pulse that asks the core to set its global interrupt-enable bit.

Relative jumps and calls add the sign-extended displacement plus one to the program counter. All program counter arithmetic wraps around the program space. Returns take the stack-top address. Conditional branches test any one of the eight status bits against a chosen polarity. Selector value 4 stands for the signed-compare bit: the unit rebuilds it from N xor V rather than trusting the stored copy. Skips step over one or two words. Instruction fetch and stack storage live elsewhere.

Top module: `nbu_next_pc`

## Requirements
- R1: While rst_n is low at a clock edge, next_pc_o, taken_o, cycles_o and set_ie_o all become zero. Otherwise every output is registered one clock after the inputs it depends on.
- R2: op_i 0 (sequential) and op_i 7 (reserved) give next_pc_o = pc_i + 1, taken_o = 0, cycles_o = 1, set_ie_o = 0.
- R3: op_i 1 (relative jump) gives next_pc_o = (pc_i + sext(offset_i) + 1) mod 2^PC_W, taken_o = 1, cycles_o = 2. The offset is OFF_W bits, two's complement.
- R4: op_i 2 (relative call) gives the same target as R3, with taken_o = 1 and cycles_o = 3.
- R5: op_i 3 (return) gives next_pc_o = ret_addr_i, taken_o = 1, cycles_o = 4, set_ie_o = 0.
- R6: op_i 4 (interrupt return) behaves as R5 but drives set_ie_o = 1. No other op_i value ever drives set_ie_o high.
- R7: op_i 5 (branch) selects status bit cond_sel_i (bit order 0 C, 1 Z, 2 N, 3 V, 5 H, 6 T, 7 I). The branch is taken when that bit equals cond_pol_i. A taken branch gives the R3 target with cycles_o = 2 and taken_o = 1. A branch that is not taken gives pc_i + 1 with cycles_o = 1 and taken_o = 0.
- R8: For a branch with cond_sel_i = 4, the tested bit is sreg_i[2] xor sreg_i[3]. The value of sreg_i[4] has no effect.
- R9: op_i 6 (skip) with skip_cond_i = 0 gives pc_i + 1 and 1 cycle, not taken. With skip_cond_i = 1 and next_two_word_i = 0 it gives pc_i + 2 and 2 cycles. With skip_cond_i = 1 and next_two_word_i = 1 it gives pc_i + 3 and 3 cycles. A skip that fires is marked taken. All results wrap modulo 2^PC_W.
- R10: skip_cond_i and next_two_word_i have no effect on any output for op_i values other than 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code (encoding in R2 to R9) |
| pc_i | input | PC_W | Address of the current instruction |
| offset_i | input | OFF_W | Signed relative displacement |
| sreg_i | input | 8 | Status bits C,Z,N,V,S,H,T,I at positions 0 to 7 |
| cond_sel_i | input | 3 | Status bit tested by a branch |
| cond_pol_i | input | 1 | Bit value that makes a branch taken |
| skip_cond_i | input | 1 | Skip test result from the operand compare |
| next_two_word_i | input | 1 | The following instruction is two words long |
| ret_addr_i | input | PC_W | Return address from the stack top |
| next_pc_o | output | PC_W | Resolved next program counter |
| taken_o | output | 1 | Control flow left the sequential path |
| cycles_o | output | 3 | Cycle cost of the instruction |
| set_ie_o | output | 1 | Request to set the global interrupt enable |

## Verification
The bench builds the unit with PC_W = 9 and OFF_W = 12. The displacement range is therefore wider than the 512-word program space, and forward and backward wrap-around of jump and branch targets comes up often under random stimulus rather than only in directed cases. The small address width also lets directed tests place the program counter at the last words of the space, so the wrap of pc + 2 and pc + 3 on skips gets exercised. Every selector and polarity is swept across all 256 status bytes.

// File: rtl/nbu_pkg.sv
// Shared definitions for the next-PC unit.
// Assumes an 8-bit status byte with the signed-compare bit at position 4.
package nbu_pkg;
    typedef enum logic [2:0] {
        OP_SEQ    = 3'd0,
        OP_RJMP   = 3'd1,
        OP_RCALL  = 3'd2,
        OP_RET    = 3'd3,
        OP_RETI   = 3'd4,
        OP_BRANCH = 3'd5,
        OP_SKIP   = 3'd6,
        OP_RSVD   = 3'd7
    } nbu_op_e;

    localparam int SREG_W     = 8;
    localparam int SEL_W      = $clog2(SREG_W);
    localparam int SIGNED_BIT = 4;
    localparam int NEG_BIT    = 2;
    localparam int OVF_BIT    = 3;
    localparam int CYC_W      = 3;
endpackage

// File: rtl/nbu_cond_sel.sv
// Branch condition selector: picks one status bit and compares it with
// the requested polarity. Assumes the signed-compare position is rebuilt
// from the negative and overflow bits instead of using the stored copy.
module nbu_cond_sel
    import nbu_pkg::*;
(
    input  logic [SREG_W-1:0] sreg_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              pol_i,
    output logic              hit_o
);
    logic [SREG_W-1:0] eff_bits;

    // Build the effective flag vector, one position per status bit.
    for (genvar i = 0; i < SREG_W; i++) begin : g_bit
        if (i == SIGNED_BIT) begin : g_signed
            assign eff_bits[i] = sreg_i[NEG_BIT] ^ sreg_i[OVF_BIT];
        end else begin : g_plain
            assign eff_bits[i] = sreg_i[i];
        end
    end

    // The condition holds when the selected bit matches the polarity.
    always_comb begin
        hit_o = (eff_bits[sel_i] == pol_i);
    end
endmodule

// File: rtl/nbu_target_calc.sv
// Address arithmetic: relative target and the sequential and skip
// successors. Assumes all results wrap modulo 2**PC_W; the offset is
// sign-extended to the wider of the two widths before the add.
module nbu_target_calc #(
    parameter int PC_W  = 10,
    parameter int OFF_W = 12
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic [PC_W-1:0]  rel_o,
    output logic [PC_W-1:0]  seq_o,
    output logic [PC_W-1:0]  skip1_o,
    output logic [PC_W-1:0]  skip2_o
);
    localparam int EXT_W = (PC_W > OFF_W) ? PC_W : OFF_W;

    logic signed [EXT_W-1:0] off_ext;
    logic        [EXT_W-1:0] pc_ext;
    logic        [EXT_W-1:0] rel_sum;

    // Widen both operands and form pc + k + 1.
    always_comb begin
        off_ext = EXT_W'($signed(offset_i));
        pc_ext  = EXT_W'(pc_i);
        rel_sum = pc_ext + off_ext + EXT_W'(1);
    end

    // Truncate back to the program space and form the fixed successors.
    always_comb begin
        rel_o   = rel_sum[PC_W-1:0];
        seq_o   = pc_i + PC_W'(1);
        skip1_o = pc_i + PC_W'(2);
        skip2_o = pc_i + PC_W'(3);
    end
endmodule

// File: rtl/nbu_cost.sv
// Cycle cost and redirect decision per operation.
// Assumes the branch hit and skip condition are already resolved.
module nbu_cost
    import nbu_pkg::*;
(
    input  nbu_op_e          op_i,
    input  logic             br_hit_i,
    input  logic             skip_cond_i,
    input  logic             two_word_i,
    output logic             taken_o,
    output logic [CYC_W-1:0] cycles_o,
    output logic             set_ie_o
);
    // Map each operation to its redirect flag, cost and interrupt request.
    always_comb begin
        taken_o  = 1'b0;
        cycles_o = CYC_W'(1);
        set_ie_o = 1'b0;
        unique case (op_i)
            OP_RJMP: begin
                taken_o  = 1'b1;
                cycles_o = CYC_W'(2);
            end
            OP_RCALL: begin
                taken_o  = 1'b1;
                cycles_o = CYC_W'(3);
            end
            OP_RET: begin
                taken_o  = 1'b1;
                cycles_o = CYC_W'(4);
            end
            OP_RETI: begin
                taken_o  = 1'b1;
                cycles_o = CYC_W'(4);
                set_ie_o = 1'b1;
            end
            OP_BRANCH: begin
                taken_o  = br_hit_i;
                cycles_o = br_hit_i ? CYC_W'(2) : CYC_W'(1);
            end
            OP_SKIP: begin
                taken_o  = skip_cond_i;
                if (skip_cond_i) begin
                    cycles_o = two_word_i ? CYC_W'(3) : CYC_W'(2);
                end
            end
            default: begin
                taken_o  = 1'b0;
                cycles_o = CYC_W'(1);
            end
        endcase
    end
endmodule

// File: rtl/nbu_next_pc.sv
// Next-PC unit top: combines condition selection, address arithmetic and
// cost lookup, then registers the result. Assumes inputs are stable
// around the clock edge; one cycle of latency; synchronous active-low reset.
module nbu_next_pc
    import nbu_pkg::*;
#(
    parameter int PC_W  = 10,
    parameter int OFF_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          op_i,
    input  logic [PC_W-1:0]     pc_i,
    input  logic [OFF_W-1:0]    offset_i,
    input  logic [SREG_W-1:0]   sreg_i,
    input  logic [SEL_W-1:0]    cond_sel_i,
    input  logic                cond_pol_i,
    input  logic                skip_cond_i,
    input  logic                next_two_word_i,
    input  logic [PC_W-1:0]     ret_addr_i,
    output logic [PC_W-1:0]     next_pc_o,
    output logic                taken_o,
    output logic [CYC_W-1:0]    cycles_o,
    output logic                set_ie_o
);
    nbu_op_e          op;
    logic             br_hit;
    logic [PC_W-1:0]  rel_pc, seq_pc, skip1_pc, skip2_pc;
    logic [PC_W-1:0]  pc_d;
    logic             taken_d, set_ie_d;
    logic [CYC_W-1:0] cycles_d;

    assign op = nbu_op_e'(op_i);

    nbu_cond_sel u_cond (
        .sreg_i (sreg_i),
        .sel_i  (cond_sel_i),
        .pol_i  (cond_pol_i),
        .hit_o  (br_hit)
    );

    nbu_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc_i     (pc_i),
        .offset_i (offset_i),
        .rel_o    (rel_pc),
        .seq_o    (seq_pc),
        .skip1_o  (skip1_pc),
        .skip2_o  (skip2_pc)
    );

    nbu_cost u_cost (
        .op_i        (op),
        .br_hit_i    (br_hit),
        .skip_cond_i (skip_cond_i),
        .two_word_i  (next_two_word_i),
        .taken_o     (taken_d),
        .cycles_o    (cycles_d),
        .set_ie_o    (set_ie_d)
    );

    // Choose the successor address for the current operation.
    always_comb begin
        unique case (op)
            OP_RJMP, OP_RCALL: pc_d = rel_pc;
            OP_RET, OP_RETI:   pc_d = ret_addr_i;
            OP_BRANCH:         pc_d = br_hit ? rel_pc : seq_pc;
            OP_SKIP: begin
                if (!skip_cond_i)         pc_d = seq_pc;
                else if (next_two_word_i) pc_d = skip2_pc;
                else                      pc_d = skip1_pc;
            end
            default:           pc_d = seq_pc;
        endcase
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o <= '0;
            taken_o   <= 1'b0;
            cycles_o  <= '0;
            set_ie_o  <= 1'b0;
        end else begin
            next_pc_o <= pc_d;
            taken_o   <= taken_d;
            cycles_o  <= cycles_d;
            set_ie_o  <= set_ie_d;
        end
    end
endmodule

// File: rtl/nbu_next_pc_chk.sv
// Protocol checker for nbu_next_pc, attached by bind.
// Assumes the one-cycle output latency of the top module.
module nbu_next_pc_chk
    import nbu_pkg::*;
#(
    parameter int PC_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic [PC_W-1:0]   pc_i,
    input logic              skip_cond_i,
    input logic              next_two_word_i,
    input logic [PC_W-1:0]   ret_addr_i,
    input logic [PC_W-1:0]   next_pc_o,
    input logic              taken_o,
    input logic [CYC_W-1:0]  cycles_o,
    input logic              set_ie_o
);
    assert_ret_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RET) |=> (next_pc_o == $past(ret_addr_i) && cycles_o == 3'd4 && !set_ie_o));

    assert_reti_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_RETI) |=> (set_ie_o && next_pc_o == $past(ret_addr_i)));

    assert_ie_only_reti_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_RETI) |=> !set_ie_o);

    assert_branch_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_BRANCH) |=> (taken_o ? (cycles_o == 3'd2)
                                          : (cycles_o == 3'd1 && next_pc_o == PC_W'($past(pc_i) + 1))));

    assert_skip_two_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SKIP && skip_cond_i && next_two_word_i) |=>
            (cycles_o == 3'd3 && taken_o && next_pc_o == PC_W'($past(pc_i) + 3)));

    assert_skip_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SKIP && !skip_cond_i) |=> (cycles_o == 3'd1 && !taken_o));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SEQ || op_i == OP_RSVD) |=>
            (!taken_o && cycles_o == 3'd1 && next_pc_o == PC_W'($past(pc_i) + 1)));

    assert_taken_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (cycles_o >= 3'd2));
endmodule

bind nbu_next_pc nbu_next_pc_chk #(.PC_W(PC_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .op_i            (op_i),
    .pc_i            (pc_i),
    .skip_cond_i     (skip_cond_i),
    .next_two_word_i (next_two_word_i),
    .ret_addr_i      (ret_addr_i),
    .next_pc_o       (next_pc_o),
    .taken_o         (taken_o),
    .cycles_o        (cycles_o),
    .set_ie_o        (set_ie_o)
);

// File: tb/nbu_next_pc_test.sv
// Self-checking bench for nbu_next_pc: swept branches, random ops, directed corners.
module nbu_next_pc_test;
    localparam int PC_W  = 9;
    localparam int OFF_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        op_i = '0;
    logic [PC_W-1:0]   pc_i = '0;
    logic [OFF_W-1:0]  offset_i = '0;
    logic [7:0]        sreg_i = '0;
    logic [2:0]        cond_sel_i = '0;
    logic              cond_pol_i = 1'b0;
    logic              skip_cond_i = 1'b0;
    logic              next_two_word_i = 1'b0;
    logic [PC_W-1:0]   ret_addr_i = '0;
    logic [PC_W-1:0]   next_pc_o;
    logic              taken_o;
    logic [2:0]        cycles_o;
    logic              set_ie_o;

    int n_cmp = 0;
    int n_bad = 0;
    int wd    = 0;

    nbu_next_pc #(.PC_W(PC_W), .OFF_W(OFF_W)) uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .pc_i(pc_i), .offset_i(offset_i),
        .sreg_i(sreg_i), .cond_sel_i(cond_sel_i), .cond_pol_i(cond_pol_i),
        .skip_cond_i(skip_cond_i), .next_two_word_i(next_two_word_i),
        .ret_addr_i(ret_addr_i), .next_pc_o(next_pc_o), .taken_o(taken_o),
        .cycles_o(cycles_o), .set_ie_o(set_ie_o)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad + 0);
            $finish;
        end
    end

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            tk;
        logic [2:0]      cyc;
        logic            ie;
    } res_t;

    function automatic logic [PC_W-1:0] wrap(input int v);
        return PC_W'(v & ((1 << PC_W) - 1));
    endfunction

    function automatic int rel(input logic [PC_W-1:0] pc, input logic [OFF_W-1:0] k);
        int ki;
        ki = int'(k);
        if (k[OFF_W-1]) ki = ki - (1 << OFF_W);
        return int'(pc) + ki + 1;
    endfunction

    // Reference model written from the requirements.
    function automatic res_t model(input logic [2:0] op, input logic [PC_W-1:0] pc,
                                   input logic [OFF_W-1:0] k, input logic [7:0] s,
                                   input logic [2:0] sel, input logic pol,
                                   input logic sc, input logic tw, input logic [PC_W-1:0] ra);
        res_t r;
        logic f;
        r = '{pc: wrap(int'(pc) + 1), tk: 1'b0, cyc: 3'd1, ie: 1'b0};
        case (op)
            3'd1: r = '{pc: wrap(rel(pc, k)), tk: 1'b1, cyc: 3'd2, ie: 1'b0};
            3'd2: r = '{pc: wrap(rel(pc, k)), tk: 1'b1, cyc: 3'd3, ie: 1'b0};
            3'd3: r = '{pc: ra, tk: 1'b1, cyc: 3'd4, ie: 1'b0};
            3'd4: r = '{pc: ra, tk: 1'b1, cyc: 3'd4, ie: 1'b1};
            3'd5: begin
                f = (sel == 3'd4) ? (s[2] ^ s[3]) : s[sel];
                if (f == pol) r = '{pc: wrap(rel(pc, k)), tk: 1'b1, cyc: 3'd2, ie: 1'b0};
            end
            3'd6: begin
                if (sc && tw)  r = '{pc: wrap(int'(pc) + 3), tk: 1'b1, cyc: 3'd3, ie: 1'b0};
                else if (sc)   r = '{pc: wrap(int'(pc) + 2), tk: 1'b1, cyc: 3'd2, ie: 1'b0};
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic [2:0] sel);
        case (op)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return (sel == 3'd4) ? "R8" : "R7";
            3'd6: return "R9";
            default: return "R2";
        endcase
    endfunction

    // Apply one operation, wait one clock, compare at the falling edge.
    task automatic run(input logic [2:0] op, input logic [PC_W-1:0] pc,
                       input logic [OFF_W-1:0] k, input logic [7:0] s,
                       input logic [2:0] sel, input logic pol, input logic sc,
                       input logic tw, input logic [PC_W-1:0] ra, input string tag);
        res_t exp, act;
        op_i = op; pc_i = pc; offset_i = k; sreg_i = s; cond_sel_i = sel;
        cond_pol_i = pol; skip_cond_i = sc; next_two_word_i = tw; ret_addr_i = ra;
        exp = model(op, pc, k, s, sel, pol, sc, tw, ra);
        @(negedge clk);
        act = '{pc: next_pc_o, tk: taken_o, cyc: cycles_o, ie: set_ie_o};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d: actual pc=%0d tk=%0b cyc=%0d ie=%0b expected pc=%0d tk=%0b cyc=%0d ie=%0b",
                     tag, op, act.pc, act.tk, act.cyc, act.ie, exp.pc, exp.tk, exp.cyc, exp.ie);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset clears outputs even with active inputs.
        op_i = 3'd4; pc_i = 9'd77; ret_addr_i = 9'd300;
        @(negedge clk); @(negedge clk);
        n_cmp++;
        if ({next_pc_o, taken_o, cycles_o, set_ie_o} !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: actual pc=%0d tk=%0b cyc=%0d ie=%0b expected all zero",
                     next_pc_o, taken_o, cycles_o, set_ie_o);
        end
        rst_n = 1'b1;

        // Directed corners.
        run(3'd0, 9'd511, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 9'd0, "R2");
        run(3'd7, 9'd20,  12'h7FF, 8'hFF, 3'd0, 1'b0, 1'b1, 1'b1, 9'd5, "R2");
        run(3'd1, 9'd500, 12'h014, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 9'd0, "R3");
        run(3'd1, 9'd3,   12'hFFB, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 9'd0, "R3");
        run(3'd1, 9'd10,  12'h800, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 9'd0, "R3");
        run(3'd2, 9'd511, 12'h7FF, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 9'd0, "R4");
        run(3'd3, 9'd100, 12'h000, 8'h80, 3'd0, 1'b0, 1'b0, 1'b0, 9'd444, "R5");
        run(3'd4, 9'd100, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 9'd1, "R6");
        run(3'd5, 9'd50,  12'h002, 8'h04, 3'd4, 1'b1, 1'b0, 1'b0, 9'd0, "R8");
        run(3'd5, 9'd50,  12'h002, 8'h1C, 3'd4, 1'b1, 1'b0, 1'b0, 9'd0, "R8");
        run(3'd5, 9'd50,  12'h002, 8'h10, 3'd4, 1'b1, 1'b0, 1'b0, 9'd0, "R8");
        run(3'd6, 9'd510, 12'h000, 8'h00, 3'd0, 1'b0, 1'b1, 1'b1, 9'd0, "R9");
        run(3'd6, 9'd511, 12'h000, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 9'd0, "R9");
        run(3'd6, 9'd42,  12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 9'd0, "R9");
        for (int op = 0; op < 6; op++) begin
            run(3'(op), 9'd200, 12'h030, 8'h5A, 3'd2, 1'b1, 1'b1, 1'b1, 9'd17, "R10");
            run(3'(op), 9'd200, 12'h030, 8'h5A, 3'd2, 1'b1, 1'b0, 1'b0, 9'd17, "R10");
        end

        // Sweep every selector and polarity over all status bytes.
        for (int sel = 0; sel < 8; sel++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int s = 0; s < 256; s++) begin
                    run(3'd5, PC_W'($urandom), OFF_W'($urandom), 8'(s), 3'(sel), 1'(pol),
                        1'($urandom), 1'($urandom), PC_W'($urandom), tag_of(3'd5, 3'(sel)));
                end
            end
        end

        // Random mix of all operations.
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op;
            logic [2:0] sel;
            op  = 3'($urandom);
            sel = 3'($urandom);
            run(op, PC_W'($urandom), OFF_W'($urandom), 8'($urandom), sel, 1'($urandom),
                1'($urandom), 1'($urandom), PC_W'($urandom), tag_of(op, sel));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule